// File: doc/BRIEF.md
# Control Store Page Reload Sequencer

This block rewrites one whole page of writable microcode store with data taken from main memory. A single write to its 16-bit reload register starts it. The written value carries a 4-bit page number in its low bits and a 12-bit memory base in its upper bits. The sequencer then freezes the microsequencer clock, loads the page number into the page register and pulses a clear of the low micro-PC bits, so that writing begins on a page boundary.

During the copy, the reload register itself serves as the main memory address counter. Its low four bits are zeroed when it is loaded, so the first word read sits at `{base, 4'h0}`. The address then advances by one per word. Each read is held until memory returns an acknowledge, so memory latency may vary. Only the low byte of each returned word goes into the store, at the page-relative index of that word.

After the 256th byte is written, the clock-enable is restored so instruction execution resumes. Input/output service grants are withheld for the whole reload.

Top module: `cs_page_loader`

## Requirements
- R1: While reset is held and after it is released, `busy`, `upc_clr`, `mem_req`, `cs_we`, `io_grant` and `page_o` are 0, and `useq_run` is 1.
- R2: One cycle after `wr_en` is sampled with the block idle, `busy` is 1, `useq_run` is 0, `page_o` equals `wr_data[3:0]`, and `upc_clr` is 1 for exactly that one cycle.
- R3: The first memory request uses address `{wr_data[15:4], 4'h0}`, and each later request uses the previous address plus one, wrapping modulo 2^16. Exactly 256 requests are issued per reload.
- R4: Exactly 256 store writes occur per reload. Write k (k = 0..255) has `cs_addr = {page, k[7:0]}` and `cs_wdata` equal to bits [7:0] of the memory word returned for request k; bits [15:8] of that word are discarded.
- R5: Once raised, `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is sampled high. Any latency of zero or more cycles is accepted.
- R6: `busy` falls and `useq_run` rises in the same cycle as the 256th store write strobe. `busy` stays high during every earlier write.
- R7: `io_grant` is 1 only in a cycle where `busy` is 0, and then follows `io_req` of the previous cycle.
- R8: A reload register write while a reload is in progress is ignored. The page, the address sequence and the write count of the running reload are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Reload register write strobe |
| wr_data | input | 16 | Reload value: base in [15:4], page in [3:0] |
| busy | output | 1 | Reload in progress |
| useq_run | output | 1 | Microsequencer clock enable (0 = frozen) |
| upc_clr | output | 1 | One-cycle pulse clearing the low micro-PC bits |
| page_o | output | 4 | Control store page register |
| mem_req | output | 1 | Main memory read request |
| mem_addr | output | 16 | Main memory read address |
| mem_ack | input | 1 | Memory access-complete, data valid |
| mem_rdata | input | 16 | Memory read data |
| cs_we | output | 1 | Control store write strobe |
| cs_addr | output | 12 | Control store write address {page, index} |
| cs_wdata | output | 8 | Control store write byte |
| io_req | input | 1 | I/O service request |
| io_grant | output | 1 | I/O service grant, held low during reload |

## Verification
The page, the frozen clock-enable and the micro-PC clear pulse are due one cycle after the register write is sampled. The clear pulse must already be gone one cycle later. Each store write appears one cycle after the acknowledge it belongs to, and the release of `busy` coincides with the last of those writes. The bench drives inputs and samples all outputs on the falling edge, so each result is read in the exact cycle it is due. A memory model checks every request address and its stability while it waits, and inserts a configurable number of wait cycles.

// File: rtl/cspr_pkg.sv
package cspr_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_GAP  = 2'd2
  } ld_state_t;
endpackage

// File: rtl/cspr_reload_reg.sv
// Reload register: holds page number and doubles as memory address counter.
module cspr_reload_reg #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      page <= '0;
    end else if (load) begin
      page <= load_val[PAGE_W-1:0];
      addr <= {load_val[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
    end else if (step) begin
      addr <= addr + ADDR_W'(1);
    end
  end

  // R3: address advances by exactly one per accepted word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    step && !load |=> (addr == $past(addr) + ADDR_W'(1)));
  // R3: low page bits of the address are zero right after a load
  a_r3_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr[PAGE_W-1:0] == '0));
endmodule

// File: rtl/cspr_ctrl.sv
// Sequencing FSM: clock freeze, request/acknowledge walk, release.
module cspr_ctrl
  import cspr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             mem_ack,
  output logic             load,
  output logic             take,
  output logic             busy,
  output logic             busy_nxt,
  output logic             useq_run,
  output logic             upc_clr,
  output logic             mem_req,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  ld_state_t state;
  logic      last;

  always_comb begin
    load     = (state == LD_IDLE) && start_req;
    take     = (state == LD_REQ) && mem_ack;
    last     = take && (idx == IDX_LAST);
    busy_nxt = (state == LD_IDLE) ? start_req : !last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LD_IDLE;
      busy     <= 1'b0;
      useq_run <= 1'b1;
      upc_clr  <= 1'b0;
      mem_req  <= 1'b0;
      idx      <= '0;
    end else begin
      upc_clr <= load;
      case (state)
        LD_IDLE: begin
          if (start_req) begin
            state    <= LD_REQ;
            busy     <= 1'b1;
            useq_run <= 1'b0;
            mem_req  <= 1'b1;
            idx      <= '0;
          end
        end
        LD_REQ: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            idx     <= idx + IDX_W'(1);
            if (last) begin
              state    <= LD_IDLE;
              busy     <= 1'b0;
              useq_run <= 1'b1;
            end else begin
              state <= LD_GAP;
            end
          end
        end
        LD_GAP: begin
          state   <= LD_REQ;
          mem_req <= 1'b1;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  // R2: a new reload freezes the clock and pulses the micro-PC clear
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (upc_clr && !useq_run));
  // R2: clock stays frozen for the whole reload
  a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |-> !useq_run);
  // R5: request held until acknowledged
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);
  // R6: release follows the final acknowledge
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    last |=> (!busy && useq_run));
endmodule

// File: rtl/cs_page_loader.sv
module cs_page_loader #(
  parameter int MEM_AW = 16,
  parameter int MEM_DW = 16,
  parameter int PAGE_W = 4,
  parameter int IDX_W  = 8,
  parameter int CS_DW  = 8,
  parameter int LANE   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [MEM_AW-1:0]       wr_data,
  output logic                    busy,
  output logic                    useq_run,
  output logic                    upc_clr,
  output logic [PAGE_W-1:0]       page_o,
  output logic                    mem_req,
  output logic [MEM_AW-1:0]       mem_addr,
  input  logic                    mem_ack,
  input  logic [MEM_DW-1:0]       mem_rdata,
  output logic                    cs_we,
  output logic [PAGE_W+IDX_W-1:0] cs_addr,
  output logic [CS_DW-1:0]        cs_wdata,
  input  logic                    io_req,
  output logic                    io_grant
);
  localparam int CS_AW   = PAGE_W + IDX_W;
  localparam int N_LANES = MEM_DW / CS_DW;

  logic             load, take, busy_nxt;
  logic [IDX_W-1:0] idx;
  logic [CS_DW-1:0] lane_byte;

  cspr_reload_reg #(.ADDR_W(MEM_AW), .PAGE_W(PAGE_W)) u_rreg (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (wr_data),
    .step     (take),
    .addr     (mem_addr),
    .page     (page_o)
  );

  cspr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_req (wr_en),
    .mem_ack   (mem_ack),
    .load      (load),
    .take      (take),
    .busy      (busy),
    .busy_nxt  (busy_nxt),
    .useq_run  (useq_run),
    .upc_clr   (upc_clr),
    .mem_req   (mem_req),
    .idx       (idx)
  );

  // Byte lane selection: parameter picks which lane of the memory word is kept
  always_comb begin
    lane_byte = '0;
    for (int i = 0; i < N_LANES; i++) begin
      if (i == LANE) lane_byte = mem_rdata[i*CS_DW +: CS_DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_we    <= 1'b0;
      cs_addr  <= '0;
      cs_wdata <= '0;
      io_grant <= 1'b0;
    end else begin
      cs_we    <= take;
      cs_addr  <= CS_AW'({page_o, idx});
      cs_wdata <= lane_byte;
      io_grant <= io_req && !busy_nxt;
    end
  end

  // R7: no I/O grant while a reload is running
  a_r7_io_locked: assert property (@(posedge clk) disable iff (rst)
    io_grant |-> !busy);
  // R4: every store write lands in the current page
  a_r4_we_page: assert property (@(posedge clk) disable iff (rst)
    cs_we |-> (cs_addr[CS_AW-1:IDX_W] == page_o));
  // R8: a register write during a reload leaves the page untouched
  a_r8_ignore_write: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && busy_nxt) |=> $stable(page_o));
  // R4: store writes happen only while busy or on the releasing cycle
  a_r4_we_in_reload: assert property (@(posedge clk) disable iff (rst)
    cs_we |-> ($past(busy)));
endmodule

// File: tb/cs_page_loader_tb.sv
`timescale 1ns/1ps
module cs_page_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        busy, useq_run, upc_clr, mem_req, cs_we, io_grant;
  logic [3:0]  page_o;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [11:0] cs_addr;
  logic [7:0]  cs_wdata;
  logic        io_req = 1'b0;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cs_page_loader u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .busy(busy), .useq_run(useq_run), .upc_clr(upc_clr), .page_o(page_o),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .cs_we(cs_we), .cs_addr(cs_addr),
    .cs_wdata(cs_wdata), .io_req(io_req), .io_grant(io_grant)
  );

  // {wr_data, latency}
  localparam logic [19:0] VECS [0:3] = '{20'hABC50, 20'h12303, 20'hFFFF1, 20'h000A2};

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] ^ a[7:0] ^ 8'h5A};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // shared monitor state
  int          mem_lat = 0;
  logic [15:0] exp_base = '0;
  logic [3:0]  exp_page = '0;
  int wr_cnt = 0, wr_err = 0, req_cnt = 0, addr_err = 0, stab_err = 0;
  int lock_err = 0, rel_err = 0, wcnt = 0;
  bit req_seen = 0;
  logic [15:0] held_addr = '0;
  logic [31:0] bad_act = '0, bad_exp = '0;

  // memory model with variable latency
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (!req_seen) begin
        if (mem_addr != 16'(exp_base + 16'(req_cnt))) begin
          addr_err++; bad_act = mem_addr; bad_exp = 16'(exp_base + 16'(req_cnt));
        end
        req_cnt++;
        req_seen = 1;
        held_addr = mem_addr;
      end else if (mem_addr != held_addr) begin
        stab_err++;
      end
      if (wcnt >= mem_lat) begin
        mem_ack = 1'b1;
        mem_rdata = memf(mem_addr);
        req_seen = 0;
      end else begin
        wcnt++;
      end
    end
  end

  // store write / release / lockout monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (io_grant && busy) lock_err++;
      if (cs_we) begin
        logic [15:0] w;
        w = memf(16'(exp_base + 16'(wr_cnt)));
        if (cs_addr != {exp_page, 8'(wr_cnt)} || cs_wdata != w[7:0]) begin
          wr_err++; bad_act = {cs_addr, cs_wdata}; bad_exp = {exp_page, 8'(wr_cnt), w[7:0]};
        end
        if (wr_cnt == 255) begin
          if (busy || !useq_run) rel_err++;
        end else if (!busy || useq_run) begin
          rel_err++;
        end
        wr_cnt++;
      end
    end
  end

  task automatic run_reload(input logic [15:0] wd, input int lat, input bit poke);
    int n;
    mem_lat = lat; exp_base = {wd[15:4], 4'h0}; exp_page = wd[3:0];
    wr_cnt = 0; wr_err = 0; req_cnt = 0; addr_err = 0; stab_err = 0;
    lock_err = 0; rel_err = 0;
    @(negedge clk); wr_en = 1'b1; wr_data = wd;
    @(negedge clk); wr_en = 1'b0;
    chk(busy && !useq_run && upc_clr && page_o == wd[3:0], "R2", "start state",
        {busy, useq_run, upc_clr, page_o}, {3'b101, wd[3:0]});
    @(negedge clk);
    chk(!upc_clr, "R2", "clear pulse one cycle", upc_clr, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      wr_en = 1'b1; wr_data = ~wd;
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      chk(page_o == exp_page && busy, "R8", "page during ignored write", page_o, exp_page);
    end
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(wr_cnt == 256, poke ? "R8" : "R4", "store write count", wr_cnt, 256);
    chk(wr_err == 0, "R4", "store address/data", bad_act, bad_exp);
    chk(addr_err == 0 && req_cnt == 256, "R3", "request addresses", bad_act, bad_exp);
    chk(stab_err == 0, "R5", "address stable while waiting", stab_err, 0);
    chk(rel_err == 0, "R6", "release with last write", rel_err, 0);
    chk(lock_err == 0, "R7", "grant during reload", lock_err, 0);
    chk(io_grant == 1'b1 && useq_run, "R7", "grant after reload", io_grant, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && useq_run && !upc_clr && !mem_req && !cs_we && !io_grant && page_o == 0,
        "R1", "during reset", {busy, useq_run, upc_clr, mem_req, cs_we, io_grant, page_o},
        {6'b010000, 4'h0});
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && useq_run && !mem_req && !cs_we && !io_grant, "R1", "after reset",
        {busy, useq_run, mem_req, cs_we, io_grant}, 5'b01000);
    io_req = 1'b1;
    @(negedge clk);
    chk(io_grant, "R7", "grant when idle", io_grant, 1);
    for (int v = 0; v < 4; v++) begin
      run_reload(VECS[v][19:4], int'(VECS[v][3:0]), 1'b0);
    end
    // corner: long latency with an ignored write mid-reload (R8, R5)
    run_reload(16'h4567, 5, 1'b1);
    // corner: restart right away at another page
    run_reload(16'h0003, 0, 1'b0);
    io_req = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!io_grant, "R7", "grant follows request low", io_grant, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule